// File: doc/BRIEF.md
# Round-robin flow scheduler with write-back

This block decides which traffic flow is served next. Behind a plain first-in first-out interface it keeps a ring of active flow identifiers and a table of per-flow backlog counters. A write announces one more queued packet for the flow named on the data input. The counter for that flow goes up, and the identifier joins the tail of the ring only when the flow was idle. A read takes the flow at the head of the ring and lowers its counter. If the flow still has packets waiting, its identifier goes back onto the tail.

Each backlogged flow therefore gets one turn per rotation, whatever its depth. A queue manager can use the block wherever a flow-ID FIFO would go, and round-robin service comes with it. The head identifier is always visible on the output (first-word fall-through). The counter table is indexed by the low bits of the identifier. The full 17-bit identifier is carried through the ring unchanged.

Top module: `rr_flow_sched`

## Requirements
- R1: After reset, or after a later reset pulse, `empty` is 1 and every backlog counter is zero.
- R2: A write for an idle flow (counter 0) sets its counter to 1 and appends its identifier to the tail of the ring. While `empty` is 0, `data_out` shows the head identifier, and the full 17 bits of the written identifier come out unchanged.
- R3: A write for a flow whose counter is already non-zero only increments the counter. The identifier is not added to the ring a second time.
- R4: A read while `empty` is 0 removes the head identifier and decrements that flow's counter. If the counter is still non-zero afterwards, the identifier is appended to the tail. Otherwise it leaves the ring.
- R5: Backlogged flows are served in rotation, one packet per flow per turn. A flow with a deeper backlog does not get consecutive turns while other flows wait.
- R6: When a read and a write occur in the same cycle, the read is applied first and then the write. If both append, the written-back identifier lands ahead of the newly inserted one. A same-cycle read and write of a flow holding one packet moves that flow to the tail with a counter of 1.
- R7: A read while `empty` is 1 is ignored and leaves all state unchanged.
- R8: A write for a flow whose counter is at its maximum (2**CNT_W-1, 15 by default) is ignored.
- R9: The counter table has 2**IDX_W entries (16 by default), indexed by data bits [IDX_W-1:0]. The ring never holds more identifiers than there are table entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd | input | 1 | Dequeue: consume the head flow for one packet |
| wr | input | 1 | Enqueue: one more packet for flow `data_in` |
| data_in | input | 17 | Flow identifier for a write |
| data_out | output | 17 | Flow identifier at the head of the ring |
| empty | output | 1 | No flow is backlogged |

## Verification
Every result is due in the first sample after the rising edge that accepts the stimulus. `data_out` and `empty` come straight from the ring registers, with no further stage. The bench therefore changes inputs and samples outputs 1 ns after each rising edge. It compares them against the expected head and empty flag for that edge. Effects that only show after several reads, such as a write-back, an ignored write or a saturated counter, are checked by draining the ring. The bench checks the exact order and number of identifiers that come out.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
   // Ring update requested by the context table for one cycle.
   typedef struct packed {
      logic pop;       // head leaves the ring
      logic push_wb;   // head identifier goes back to the tail
      logic push_new;  // newly active flow joins the tail (after push_wb)
   } ring_op_t;
endpackage

// File: rtl/rrs_ctx_table.sv
module rrs_ctx_table
   import rrs_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             deq_req,
   input  logic [IDX_W-1:0] deq_idx,
   input  logic             enq_req,
   input  logic [IDX_W-1:0] enq_idx,
   output ring_op_t         op
);
   localparam int NF = 2 ** IDX_W;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt [NF];
   logic [CNT_W-1:0] deq_left;
   logic [CNT_W-1:0] enq_mid;
   logic             enq_ok;

   // Dequeue path first, enqueue path sees its result.
   always_comb begin
      deq_left = cnt[deq_idx] - CNT_W'(1);
      enq_mid  = (deq_req && (deq_idx == enq_idx)) ? deq_left : cnt[enq_idx];
      enq_ok   = enq_req && (enq_mid != CNT_MAX);
      op.pop      = deq_req;
      op.push_wb  = deq_req && (deq_left != '0);
      op.push_new = enq_ok && (enq_mid == '0);
   end

   for (genvar g = 0; g < NF; g++) begin : g_flow
      logic dec, inc;
      assign dec = deq_req && (deq_idx == IDX_W'(g));
      assign inc = enq_ok && (enq_idx == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) cnt[g] <= '0;
         else        cnt[g] <= cnt[g] - CNT_W'(dec) + CNT_W'(inc);
      end
   end
endmodule

// File: rtl/rrs_ring.sv
module rrs_ring
   import rrs_pkg::*;
#(
   parameter int ID_W  = 17,
   parameter int PTR_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  ring_op_t        op,
   input  logic [ID_W-1:0] new_id,
   output logic [ID_W-1:0] head_id,
   output logic [PTR_W:0]  occupancy
);
   localparam int DEPTH = 2 ** PTR_W;

   logic [ID_W-1:0]  mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr;

   assign head_id = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (op.push_wb)  mem[wr_ptr] <= head_id;
      if (op.push_new) mem[wr_ptr + PTR_W'(op.push_wb)] <= new_id;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr    <= '0;
         wr_ptr    <= '0;
         occupancy <= '0;
      end else begin
         rd_ptr    <= rd_ptr + PTR_W'(op.pop);
         wr_ptr    <= wr_ptr + PTR_W'(op.push_wb) + PTR_W'(op.push_new);
         occupancy <= occupancy + (PTR_W+1)'(op.push_wb)
                      + (PTR_W+1)'(op.push_new) - (PTR_W+1)'(op.pop);
      end
   end
endmodule

// File: rtl/rr_flow_sched.sv
module rr_flow_sched
   import rrs_pkg::*;
#(
   parameter int ID_W  = 17,
   parameter int IDX_W = 4,
   parameter int CNT_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd,
   input  logic            wr,
   input  logic [ID_W-1:0] data_in,
   output logic [ID_W-1:0] data_out,
   output logic            empty
);
   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("rr_flow_sched: IDX_W out of range");
   end
   if (ID_W < IDX_W) begin : g_bad_id
      $error("rr_flow_sched: ID_W narrower than IDX_W");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("rr_flow_sched: CNT_W must be positive");
   end

   ring_op_t       op;
   logic [IDX_W:0] occ;
   logic           deq_req;

   assign empty   = (occ == '0);
   assign deq_req = rd && !empty;

   rrs_ctx_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctx (
      .clk     (clk),
      .rst_n   (rst_n),
      .deq_req (deq_req),
      .deq_idx (data_out[IDX_W-1:0]),
      .enq_req (wr),
      .enq_idx (data_in[IDX_W-1:0]),
      .op      (op)
   );

   rrs_ring #(.ID_W(ID_W), .PTR_W(IDX_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .new_id    (data_in),
      .head_id   (data_out),
      .occupancy (occ)
   );
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
   parameter int ID_W  = 17,
   parameter int IDX_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rd,
   input logic            wr,
   input logic [ID_W-1:0] data_in,
   input logic [ID_W-1:0] data_out,
   input logic            empty,
   input logic [IDX_W:0]  occupancy
);
   localparam int NF = 2 ** IDX_W;

   a_r2_wr_into_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && empty) |=> (!empty && data_out == $past(data_in)));

   a_r3_head_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !rd) |=> (!empty && $stable(data_out)));

   a_r7_rd_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && empty && !wr) |=> empty);

   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= (IDX_W+1)'(NF));

   a_r4_pop_progress: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !wr && occupancy == 1) |=> (occupancy <= 1));
endmodule

bind rr_flow_sched rrs_checker #(.ID_W(ID_W), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd        (rd),
   .wr        (wr),
   .data_in   (data_in),
   .data_out  (data_out),
   .empty     (empty),
   .occupancy (occ)
);

// File: tb/test_rr_flow_sched.sv
`timescale 1ns/1ps
module test_rr_flow_sched;
   localparam logic [16:0] FA = 17'h10003;  // index 3, upper bit set (R9)
   localparam logic [16:0] FB = 17'h00005;
   localparam logic [16:0] FC = 17'h0000A;
   localparam logic [16:0] NO = 17'h00000;
   localparam int NV = 17;
   // {req[4], wr, rd, din[17], exp_empty, exp_dout[17]}
   localparam logic [40:0] VEC [NV] = '{
      {4'd2, 1'b1, 1'b0, FA, 1'b0, FA},  // R2 idle flow A joins
      {4'd3, 1'b1, 1'b0, FA, 1'b0, FA},  // R3 A count 2, not re-added
      {4'd2, 1'b1, 1'b0, FB, 1'b0, FA},  // R2 B joins
      {4'd2, 1'b1, 1'b0, FC, 1'b0, FA},  // R2 C joins
      {4'd4, 1'b0, 1'b1, NO, 1'b0, FB},  // R4 A written back
      {4'd5, 1'b0, 1'b1, NO, 1'b0, FC},  // R5 B leaves
      {4'd5, 1'b0, 1'b1, NO, 1'b0, FA},  // R5 C leaves, A turn
      {4'd6, 1'b1, 1'b1, FB, 1'b0, FB},  // R6 A drained, B inserted
      {4'd6, 1'b1, 1'b1, FB, 1'b0, FB},  // R6 same flow, count 1
      {4'd2, 1'b1, 1'b0, FA, 1'b0, FB},  // R2
      {4'd3, 1'b1, 1'b0, FB, 1'b0, FB},  // R3 B count 2
      {4'd6, 1'b1, 1'b1, FC, 1'b0, FA},  // R6 ring A,B,C
      {4'd6, 1'b0, 1'b1, NO, 1'b0, FB},  // R6 write-back ahead of insert
      {4'd6, 1'b0, 1'b1, NO, 1'b0, FC},  // R6
      {4'd4, 1'b0, 1'b1, NO, 1'b1, NO},  // R4 last flow leaves
      {4'd7, 1'b0, 1'b1, NO, 1'b1, NO},  // R7 read on empty
      {4'd7, 1'b1, 1'b0, FC, 1'b0, FC}   // R7 state untouched
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd = 1'b0, wr = 1'b0;
   logic [16:0] data_in = '0;
   logic [16:0] data_out;
   logic        empty;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   rr_flow_sched i_rr_flow_sched (
      .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr),
      .data_in(data_in), .data_out(data_out), .empty(empty));

   task automatic step(input logic w, input logic r, input logic [16:0] d);
      wr = w; rd = r; data_in = d;
      @(posedge clk); #1;
      wr = 1'b0; rd = 1'b0;
   endtask

   task automatic check(input string req, input logic exp_e, input logic [16:0] exp_d);
      checks++;
      if (empty !== exp_e || (!exp_e && data_out !== exp_d)) begin
         errors++;
         $display("FAIL %s: empty=%0b data_out=%h expected empty=%0b data_out=%h",
                  req, empty, data_out, exp_e, exp_d);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1", 1'b1, NO);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][36], VEC[i][35], VEC[i][34:18]);
         check($sformatf("R%0d vec%0d", VEC[i][40:37], i), VEC[i][17], VEC[i][16:0]);
      end
      // R1: reset pulse with a flow queued clears everything
      step(1'b1, 1'b0, FA);
      rst_n = 1'b0;
      @(posedge clk); #1;
      check("R1 mid-run", 1'b1, NO);
      rst_n = 1'b1;
      // R8: sixteen writes, counter stops at 15
      for (int i = 0; i < 16; i++) step(1'b1, 1'b0, FB);
      check("R8 after fill", 1'b0, FB);
      for (int i = 0; i < 14; i++) begin
         step(1'b0, 1'b1, NO);
         check("R8 drain", 1'b0, FB);
      end
      step(1'b0, 1'b1, NO);
      check("R8 fifteenth read empties", 1'b1, NO);
      // R9/R5: all sixteen flows active, served once each in order
      for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 17'(i) | 17'h10000);
      for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 17'(i) | 17'h10000);
      for (int i = 0; i < 32; i++) begin
         check("R9 full ring order", 1'b0, 17'(i % 16) | 17'h10000);
         step(1'b0, 1'b1, NO);
      end
      check("R5 ring drained", 1'b1, NO);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule